// File: doc/BRIEF.md
# Serial Test Word Loader for a Six-Channel Converter

This block gives test access to an embedded six-channel 10-bit converter through a handful of pins. A single serial data line is sampled on every edge of a fast bit clock. Every ten bits are gathered into one 10-bit word, which is then placed in a holding register. The bit clock runs ten times faster than the converter's word rate, so the held word changes once per ten bit clocks. A one-cycle strobe marks each update and serves as the conversion-rate tick.

A 3-bit path select chooses how each channel is driven. Codes 0 to 5 route the held test word onto that one channel. Codes 6 and 7 leave every channel on its functional path. A channel that is not under test always passes its own functional 10-bit word through, with no register and no delay. At most one channel is ever overridden.

Top module: `stp_loader_top`

## Requirements
- R1: A synchronous active-high reset clears the bit counter, the holding register and the strobe. The edge after a reset edge shows a held word of 0 and the strobe low.
- R2: Bits are taken most significant first. The first bit sampled after reset or after a word boundary becomes bit 9 of the held word, and the last bit becomes bit 0.
- R3: The held word changes only on the edge that samples the tenth bit of a group. Between those edges it stays stable.
- R4: The word strobe is high for exactly one cycle in every ten. It first rises on the tenth edge after reset is released, in the same cycle in which the new held word appears.
- R5: When the path select is N, with N from 0 to 5, output channel N carries the held test word.
- R6: When the path select is N, with N from 0 to 5, every other output channel equals its own functional input.
- R7: When the path select is 6 or 7, every output channel equals its functional input.
- R8: The functional path is combinational. A change on a functional input shows on the matching output in the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock, ten times the word rate |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial test data, one bit per clock, MSB first |
| path_sel | input | 3 | 0-5 selects the channel under test; 6-7 selects all functional |
| func_bus | input | 60 | Six functional words; channel c is in bits [10c+9:10c] |
| dac_bus | output | 60 | Six words to the converter; channel c is in bits [10c+9:10c] |
| word_stb | output | 1 | One-cycle pulse when a new test word is held |

## Verification
The assertions assume that reset is high from the first clock edge. This aligns the bit counter with a known word boundary. They also assume that the serial line and the path select change only away from the rising edge. The bench holds reset from time zero, changes every input on the falling edge, and applies one mid-word reset to check that a partial group is dropped. The bench also changes the path select and the functional words between test words, which checks that routing reacts without waiting for a word boundary.

// File: rtl/stp_pkg.sv
package stp_pkg;

    localparam int unsigned DEF_WORD_W = 10;
    localparam int unsigned DEF_NUM_CH = 6;
    localparam int unsigned DEF_SEL_W  = 3;

    // Routing decision derived from the path select code
    typedef struct packed {
        logic                  test_en;
        logic [DEF_SEL_W-1:0]  ch;
    } route_t;

    function automatic route_t decode_sel(logic [DEF_SEL_W-1:0] code, int unsigned num_ch);
        route_t r;
        r.test_en = (int'(code) < int'(num_ch));
        r.ch      = code;
        return r;
    endfunction

endpackage

// File: rtl/stp_deser.sv
module stp_deser #(
    parameter int unsigned WORD_W = stp_pkg::DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_in,
    output logic [WORD_W-1:0] word_q,
    output logic              word_stb
);
    localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [CNT_W-1:0]  bit_cnt;
    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] shreg_nx;

    assign shreg_nx = {shreg[WORD_W-2:0], ser_in};

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt  <= '0;
            shreg    <= '0;
            word_q   <= '0;
            word_stb <= 1'b0;
        end else begin
            shreg <= shreg_nx;
            if (bit_cnt == LAST) begin
                bit_cnt  <= '0;
                word_q   <= shreg_nx;
                word_stb <= 1'b1;
            end else begin
                bit_cnt  <= bit_cnt + 1'b1;
                word_stb <= 1'b0;
            end
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (word_q == '0 && !word_stb));

    assert_msb_first_R2: assert property (@(posedge clk) disable iff (rst)
        word_stb |-> (word_q[0] == $past(ser_in)));

    assert_hold_stable_R3: assert property (@(posedge clk) disable iff (rst)
        !word_stb |-> $stable(word_q));

    assert_stb_single_R4: assert property (@(posedge clk) disable iff (rst)
        word_stb |=> !word_stb);

    assert_cnt_range_R4: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= LAST);

endmodule

// File: rtl/stp_route.sv
module stp_route #(
    parameter int unsigned WORD_W = stp_pkg::DEF_WORD_W,
    parameter int unsigned NUM_CH = stp_pkg::DEF_NUM_CH,
    parameter int unsigned SEL_W  = stp_pkg::DEF_SEL_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [SEL_W-1:0]         path_sel,
    input  logic [WORD_W-1:0]        test_word,
    input  logic [NUM_CH*WORD_W-1:0] func_bus,
    output logic [NUM_CH*WORD_W-1:0] dac_bus
);
    import stp_pkg::*;

    route_t route;
    assign route = decode_sel(DEF_SEL_W'(path_sel), NUM_CH);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [WORD_W-1:0] f_w;
        logic [WORD_W-1:0] o_w;
        logic              pick;

        assign f_w  = func_bus[c*WORD_W +: WORD_W];
        assign pick = route.test_en && (route.ch == DEF_SEL_W'(c));
        assign o_w  = pick ? test_word : f_w;
        assign dac_bus[c*WORD_W +: WORD_W] = o_w;

        assert_test_path_R5: assert property (@(posedge clk) disable iff (rst)
            (path_sel == SEL_W'(c)) |-> (o_w == test_word));

        assert_pass_other_R6: assert property (@(posedge clk) disable iff (rst)
            (path_sel != SEL_W'(c) && int'(path_sel) < int'(NUM_CH)) |-> (o_w == f_w));

        assert_all_func_R7: assert property (@(posedge clk) disable iff (rst)
            (int'(path_sel) >= int'(NUM_CH)) |-> (o_w == f_w));
    end

endmodule

// File: rtl/stp_loader_top.sv
module stp_loader_top #(
    parameter int unsigned WORD_W = stp_pkg::DEF_WORD_W,
    parameter int unsigned NUM_CH = stp_pkg::DEF_NUM_CH,
    parameter int unsigned SEL_W  = stp_pkg::DEF_SEL_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ser_in,
    input  logic [SEL_W-1:0]         path_sel,
    input  logic [NUM_CH*WORD_W-1:0] func_bus,
    output logic [NUM_CH*WORD_W-1:0] dac_bus,
    output logic                     word_stb
);
    logic [WORD_W-1:0] held_word;

    stp_deser #(.WORD_W(WORD_W)) u_deser (
        .clk      (clk),
        .rst      (rst),
        .ser_in   (ser_in),
        .word_q   (held_word),
        .word_stb (word_stb)
    );

    stp_route #(.WORD_W(WORD_W), .NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_route (
        .clk       (clk),
        .rst       (rst),
        .path_sel  (path_sel),
        .test_word (held_word),
        .func_bus  (func_bus),
        .dac_bus   (dac_bus)
    );

endmodule

// File: tb/stp_loader_top_tb_top.sv
module stp_loader_top_tb_top;
    localparam int W = 10;
    localparam int N = 6;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ser_in = 1'b0;
    logic [2:0]   path_sel = 3'd0;
    logic [N*W-1:0] func_bus = '0;
    logic [N*W-1:0] dac_bus;
    logic         word_stb;

    int n_chk = 0;
    int n_fail = 0;
    logic [W-1:0] exp_q[$];
    logic [W-1:0] last_word = '0;
    int gap = 0;

    always #5 clk = ~clk;

    stp_loader_top dut_i (
        .clk(clk), .rst(rst), .ser_in(ser_in), .path_sel(path_sel),
        .func_bus(func_bus), .dac_bus(dac_bus), .word_stb(word_stb)
    );

    function automatic logic [W-1:0] chan(logic [N*W-1:0] bus, int c);
        return bus[c*W +: W];
    endfunction

    task automatic chk(bit ok, string req, int act, int exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Driver: presents ten bits MSB first, pushing the expected word before the last edge
    task automatic send_word(logic [W-1:0] w);
        for (int i = W - 1; i >= 0; i--) begin
            ser_in = w[i];
            if (i == 0) exp_q.push_back(w);
            @(negedge clk);
        end
    endtask

    task automatic set_func(int seed);
        for (int c = 0; c < N; c++)
            func_bus[c*W +: W] = W'(c * 97 + seed * 13 + 5);
    endtask

    // Monitor / scoreboard: samples 2 ns after each rising edge
    always @(posedge clk) begin
        #2;
        if (rst) begin
            gap = 0;
            last_word = '0;
        end else begin
            gap++;
            if (word_stb) begin
                logic [W-1:0] e;
                chk(exp_q.size() != 0, "R4 strobe with no word sent", 1, 0);
                e = (exp_q.size() != 0) ? exp_q.pop_front() : '0;
                chk(gap == W, "R4 strobe spacing", gap, W);
                gap = 0;
                last_word = e;
                for (int c = 0; c < N; c++) begin
                    if (int'(path_sel) == c)
                        chk(chan(dac_bus, c) == e, "R5 R2 test word on channel", chan(dac_bus, c), e);
                    else if (path_sel < 3'd6)
                        chk(chan(dac_bus, c) == chan(func_bus, c), "R6 other channel functional", chan(dac_bus, c), chan(func_bus, c));
                    else
                        chk(chan(dac_bus, c) == chan(func_bus, c), "R7 all functional", chan(dac_bus, c), chan(func_bus, c));
                end
            end else if (path_sel < 3'd6) begin
                chk(chan(dac_bus, int'(path_sel)) == last_word, "R3 held word stable", chan(dac_bus, int'(path_sel)), last_word);
            end
        end
    end

    initial begin
        #(20000 * 10);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        set_func(1);
        repeat (3) @(negedge clk);
        chk(chan(dac_bus, 0) == '0, "R1 reset held word", chan(dac_bus, 0), 0);
        chk(word_stb == 1'b0, "R1 reset strobe", word_stb, 0);

        rst = 1'b0;
        send_word(10'h3FF);
        send_word(10'h000);
        send_word(10'h200);   // R2: only the first bit set
        send_word(10'h001);   // R2: only the last bit set
        send_word(10'h2AA);
        path_sel = 3'd3; set_func(2);
        send_word(10'h155);
        send_word(10'h0F0);
        path_sel = 3'd5;
        send_word(10'h123);
        path_sel = 3'd6;
        send_word(10'h3C3);
        path_sel = 3'd7; set_func(3);
        send_word(10'h081);

        // R8: functional change visible without a clock edge
        set_func(9);
        #1;
        for (int c = 0; c < N; c++)
            chk(chan(dac_bus, c) == chan(func_bus, c), "R8 combinational pass", chan(dac_bus, c), chan(func_bus, c));
        path_sel = 3'd2;
        #1;
        chk(chan(dac_bus, 2) == 10'h081, "R5 select switch shows held word", chan(dac_bus, 2), 10'h081);
        chk(chan(dac_bus, 4) == chan(func_bus, 4), "R6 neighbour unaffected", chan(dac_bus, 4), chan(func_bus, 4));
        @(negedge clk);

        // Mid-word reset drops the partial group (R1)
        path_sel = 3'd0;
        for (int i = 0; i < 4; i++) begin
            ser_in = 1'b1;
            @(negedge clk);
        end
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(chan(dac_bus, 0) == '0, "R1 mid-word reset clears word", chan(dac_bus, 0), 0);
        chk(word_stb == 1'b0, "R1 mid-word reset strobe", word_stb, 0);
        rst = 1'b0;
        send_word(10'h2C5);
        send_word(10'h13A);
        @(negedge clk);
        chk(exp_q.size() == 0, "R4 every word strobed", exp_q.size(), 0);
        finish_run();
    end

endmodule